// File: doc/BRIEF.md
# Rotating Register Stack with Fixed-Index Packed View

This block holds eight 80-bit entries that can be reached in two ways. Stack-mode commands address the entries relative to a 3-bit top pointer, so that stack slot i (written ST(i) below) is the entry sitting i places above the top. Packed-integer commands address the same storage by absolute index 0 to 7 and see only the low 64 bits of each entry. Each entry carries one valid bit. The block supports the following operations:

- pushing a value onto the stack;
- popping the top of stack;
- copying between the top of stack and any other slot, in either direction;
- swapping any slot with the top of stack;
- writing a packed 64-bit value;
- entering packed mode without writing.

Every stack-to-stack operation has the top of stack as one of its two operands. Commands arrive on one port: an opcode, an index and a data word, taken at every rising clock edge. The read side is combinational from the stored state. It returns the following:

- the top of stack;
- the stack slot named by a separate read index;
- the packed entry at that same index taken as an absolute index;
- one lane of that packed entry, 8, 16, 32 or 64 bits wide, chosen by size and lane inputs.

A command that would push onto an occupied entry, pop an empty one, or read an empty operand does not change any state. Instead it raises a fault flag for one cycle.

Top module: `stkreg_alias`

## Requirements
- R1: After reset the top pointer is 0, every entry is empty with data 0, and the fault flag is low. Opcode 3'd0 (no operation) changes no state and leaves the fault flag low.
- R2: Opcode 3'd1 (push) moves the top pointer to (top-1) mod 8. It then writes cmd_data into the new top entry and marks that entry valid.
- R3: Opcode 3'd2 (pop) marks the current top entry empty and moves the top pointer to (top+1) mod 8. The stored data bits of that entry are kept.
- R4: The following commands fault: a push whose target entry (top-1) mod 8 is valid, a pop of an empty top entry, and any copy or swap whose source operand is empty. A faulting command leaves the top pointer, the valid bits and the data unchanged. fault_q is high for exactly the one cycle after a faulting command and low after every other command.
- R5: Stack slot i is physical entry (top+i) mod 8. sti_q and sti_valid show the data and valid bit of slot rd_idx, and st0_q and st0_valid show slot 0.
- R6: Opcode 3'd3 copies slot 0 into slot cmd_idx and marks that slot valid. Opcode 3'd4 copies slot cmd_idx into slot 0 and marks slot 0 valid. Neither opcode moves the top pointer.
- R7: Opcode 3'd5 swaps slot cmd_idx with slot 0 in a single clock edge. It requires both slots to be valid.
- R8: Opcode 3'd6 (packed write) stores cmd_data[63:0] into the low 64 bits of physical entry cmd_idx and sets bits [79:64] of that entry to all ones. It also sets the top pointer to 0 and marks all entries valid.
- R9: Opcode 3'd7 (packed enter) sets the top pointer to 0 and marks all entries valid, without changing any data bits.
- R10: mm_q shows bits [63:0] of physical entry rd_idx, whatever the value of the top pointer.
- R11: lane_q returns one lane of mm_q, right-aligned and zero-extended. lane_sz 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit lanes. The lane number is lane_sel modulo the number of lanes of that size, and lane 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | 3 | Stack slot for stack commands, physical entry for packed write |
| cmd_data | input | 80 | Write data |
| rd_idx | input | 3 | Read index: stack slot for sti_q, physical entry for mm_q |
| lane_sz | input | 2 | Lane size select for lane_q |
| lane_sel | input | 3 | Lane number for lane_q |
| top_q | output | 3 | Current top pointer |
| fault_q | output | 1 | Previous command faulted |
| st0_q | output | 80 | Data of slot 0 |
| st0_valid | output | 1 | Valid bit of slot 0 |
| sti_q | output | 80 | Data of slot rd_idx |
| sti_valid | output | 1 | Valid bit of slot rd_idx |
| mm_q | output | 64 | Low 64 bits of physical entry rd_idx |
| lane_q | output | 64 | Selected lane of mm_q, zero-extended |

## Verification
The bench builds the block with its default parameters: eight entries, 80-bit entries and a 64-bit packed view. With only eight entries, a few pushes wrap the top pointer past zero, and the full and empty faults occur often under random traffic. This makes the modulo-8 slot mapping, and its difference from the fixed packed mapping, visible on almost every read. The 64-bit packed width lets the bench exercise all four lane sizes, including lane numbers that exceed the lane count and must wrap.

// File: rtl/stkreg_pkg.sv
package stkreg_pkg;
  localparam int DEF_ENTRIES = 8;
  localparam int DEF_WIDTH   = 80;
  localparam int DEF_LOW_W   = 64;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_PUSH       = 3'd1,
    OP_POP        = 3'd2,
    OP_ST0_TO_STI = 3'd3,
    OP_STI_TO_ST0 = 3'd4,
    OP_XCHG       = 3'd5,
    OP_MM_WR      = 3'd6,
    OP_MM_ENTER   = 3'd7
  } stk_op_e;
endpackage

// File: rtl/stkreg_addr.sv
module stkreg_addr #(
  parameter int ENTRIES = stkreg_pkg::DEF_ENTRIES,
  localparam int PTR_W = $clog2(ENTRIES)
) (
  input  logic [PTR_W-1:0] top,
  input  logic [PTR_W-1:0] cmd_idx,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [PTR_W-1:0] phys_top,
  output logic [PTR_W-1:0] phys_push,
  output logic [PTR_W-1:0] phys_cmd,
  output logic [PTR_W-1:0] phys_rd
);
  // relative slot to physical entry, wrapping at the power-of-two depth
  function automatic logic [PTR_W-1:0] rel2phys(input logic [PTR_W-1:0] t,
                                                input logic [PTR_W-1:0] i);
    return t + i;
  endfunction

  assign phys_top  = top;
  assign phys_push = top - PTR_W'(1);
  assign phys_cmd  = rel2phys(top, cmd_idx);
  assign phys_rd   = rel2phys(top, rd_idx);
endmodule

// File: rtl/stkreg_bank.sv
module stkreg_bank #(
  parameter int ENTRIES = stkreg_pkg::DEF_ENTRIES,
  parameter int WIDTH   = stkreg_pkg::DEF_WIDTH,
  localparam int PTR_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wa_en,
  input  logic [PTR_W-1:0]   wa_idx,
  input  logic [WIDTH-1:0]   wa_data,
  input  logic               wa_vld,
  input  logic               wb_en,
  input  logic [PTR_W-1:0]   wb_idx,
  input  logic [WIDTH-1:0]   wb_data,
  input  logic               wb_vld,
  input  logic               all_vld_set,
  output logic [WIDTH-1:0]   ent_q [ENTRIES],
  output logic [ENTRIES-1:0] vld_q
);
  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    logic [WIDTH-1:0] d_r;
    logic             v_r;
    wire hit_a = wa_en && (wa_idx == PTR_W'(k));
    wire hit_b = wb_en && (wb_idx == PTR_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_r <= '0;
        v_r <= 1'b0;
      end else begin
        if (all_vld_set) v_r <= 1'b1;
        if (hit_a) begin
          d_r <= wa_data;
          v_r <= wa_vld;
        end
        if (hit_b) begin
          d_r <= wb_data;
          v_r <= wb_vld;
        end
      end
    end

    assign ent_q[k] = d_r;
    assign vld_q[k] = v_r;
  end
endmodule

// File: rtl/stkreg_ctrl.sv
module stkreg_ctrl
  import stkreg_pkg::*;
#(
  parameter int PTR_W = 3,
  parameter int WIDTH = stkreg_pkg::DEF_WIDTH,
  parameter int LOW_W = stkreg_pkg::DEF_LOW_W,
  localparam int HI_W = WIDTH - LOW_W
) (
  input  stk_op_e          op,
  input  logic [PTR_W-1:0] cmd_idx,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic [PTR_W-1:0] phys_top,
  input  logic [PTR_W-1:0] phys_push,
  input  logic [PTR_W-1:0] phys_cmd,
  input  logic [WIDTH-1:0] st0_d,
  input  logic             st0_v,
  input  logic [WIDTH-1:0] sti_d,
  input  logic             sti_v,
  input  logic             push_tgt_v,
  output logic             wa_en,
  output logic [PTR_W-1:0] wa_idx,
  output logic [WIDTH-1:0] wa_data,
  output logic             wa_vld,
  output logic             wb_en,
  output logic [PTR_W-1:0] wb_idx,
  output logic [WIDTH-1:0] wb_data,
  output logic             wb_vld,
  output logic             all_vld_set,
  output logic             top_we,
  output logic [PTR_W-1:0] top_nx,
  output logic             fault_nx,
  output logic             ev_push_ok,
  output logic             ev_pop_ok,
  output logic             ev_mm_op
);
  // packed write image: low lanes from the command, upper bits forced high
  function automatic logic [WIDTH-1:0] mm_image(input logic [WIDTH-1:0] d);
    return {{HI_W{1'b1}}, d[LOW_W-1:0]};
  endfunction

  always_comb begin
    wa_en       = 1'b0;
    wa_idx      = phys_top;
    wa_data     = st0_d;
    wa_vld      = 1'b1;
    wb_en       = 1'b0;
    wb_idx      = phys_cmd;
    wb_data     = st0_d;
    wb_vld      = 1'b1;
    all_vld_set = 1'b0;
    top_we      = 1'b0;
    top_nx      = phys_top;
    fault_nx    = 1'b0;
    ev_push_ok  = 1'b0;
    ev_pop_ok   = 1'b0;
    ev_mm_op    = 1'b0;
    unique case (op)
      OP_PUSH: begin
        if (push_tgt_v) fault_nx = 1'b1;
        else begin
          wa_en      = 1'b1;
          wa_idx     = phys_push;
          wa_data    = cmd_data;
          top_we     = 1'b1;
          top_nx     = phys_push;
          ev_push_ok = 1'b1;
        end
      end
      OP_POP: begin
        if (!st0_v) fault_nx = 1'b1;
        else begin
          wa_en     = 1'b1;
          wa_vld    = 1'b0;
          top_we    = 1'b1;
          top_nx    = phys_top + PTR_W'(1);
          ev_pop_ok = 1'b1;
        end
      end
      OP_ST0_TO_STI: begin
        if (!st0_v) fault_nx = 1'b1;
        else wb_en = 1'b1;
      end
      OP_STI_TO_ST0: begin
        if (!sti_v) fault_nx = 1'b1;
        else begin
          wa_en   = 1'b1;
          wa_data = sti_d;
        end
      end
      OP_XCHG: begin
        if (!st0_v || !sti_v) fault_nx = 1'b1;
        else begin
          wa_en   = 1'b1;
          wa_data = sti_d;
          wb_en   = 1'b1;
        end
      end
      OP_MM_WR: begin
        wa_en       = 1'b1;
        wa_idx      = cmd_idx;
        wa_data     = mm_image(cmd_data);
        all_vld_set = 1'b1;
        top_we      = 1'b1;
        top_nx      = '0;
        ev_mm_op    = 1'b1;
      end
      OP_MM_ENTER: begin
        all_vld_set = 1'b1;
        top_we      = 1'b1;
        top_nx      = '0;
        ev_mm_op    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stkreg_lanes.sv
module stkreg_lanes #(
  parameter int LOW_W = stkreg_pkg::DEF_LOW_W
) (
  input  logic [LOW_W-1:0] word,
  input  logic [1:0]       sz,
  input  logic [2:0]       sel,
  output logic [LOW_W-1:0] lane
);
  function automatic logic [LOW_W-1:0] lane_pick(input logic [LOW_W-1:0] w,
                                                 input logic [1:0] s,
                                                 input logic [2:0] n);
    logic [LOW_W-1:0] sh;
    unique case (s)
      2'd0: begin
        sh = w >> (32'(n) * 8);
        return sh & LOW_W'(8'hFF);
      end
      2'd1: begin
        sh = w >> (32'(n[1:0]) * 16);
        return sh & LOW_W'(16'hFFFF);
      end
      2'd2: begin
        sh = w >> (32'(n[0]) * 32);
        return sh & LOW_W'(32'hFFFF_FFFF);
      end
      default: return w;
    endcase
  endfunction

  assign lane = lane_pick(word, sz, sel);
endmodule

// File: rtl/stkreg_alias.sv
module stkreg_alias
  import stkreg_pkg::*;
#(
  parameter int ENTRIES = stkreg_pkg::DEF_ENTRIES,
  parameter int WIDTH   = stkreg_pkg::DEF_WIDTH,
  parameter int LOW_W   = stkreg_pkg::DEF_LOW_W,
  localparam int PTR_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_op,
  input  logic [PTR_W-1:0] cmd_idx,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic [PTR_W-1:0] rd_idx,
  input  logic [1:0]       lane_sz,
  input  logic [2:0]       lane_sel,
  output logic [PTR_W-1:0] top_q,
  output logic             fault_q,
  output logic [WIDTH-1:0] st0_q,
  output logic             st0_valid,
  output logic [WIDTH-1:0] sti_q,
  output logic             sti_valid,
  output logic [LOW_W-1:0] mm_q,
  output logic [LOW_W-1:0] lane_q
);
  logic [PTR_W-1:0]   top_r;
  logic               fault_r;
  logic [PTR_W-1:0]   phys_top, phys_push, phys_cmd, phys_rd;
  logic [WIDTH-1:0]   ent_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic               wa_en, wa_vld, wb_en, wb_vld, all_vld_set;
  logic [PTR_W-1:0]   wa_idx, wb_idx, top_nx;
  logic [WIDTH-1:0]   wa_data, wb_data;
  logic               top_we, fault_nx;
  // named events for the checker
  logic               ev_push_ok, ev_pop_ok, ev_mm_op;

  stkreg_addr #(.ENTRIES(ENTRIES)) addr_i (
    .top(top_r), .cmd_idx(cmd_idx), .rd_idx(rd_idx),
    .phys_top(phys_top), .phys_push(phys_push),
    .phys_cmd(phys_cmd), .phys_rd(phys_rd)
  );

  stkreg_ctrl #(.PTR_W(PTR_W), .WIDTH(WIDTH), .LOW_W(LOW_W)) ctrl_i (
    .op(stk_op_e'(cmd_op)), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .phys_top(phys_top), .phys_push(phys_push), .phys_cmd(phys_cmd),
    .st0_d(ent_q[phys_top]), .st0_v(vld_q[phys_top]),
    .sti_d(ent_q[phys_cmd]), .sti_v(vld_q[phys_cmd]),
    .push_tgt_v(vld_q[phys_push]),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data), .wa_vld(wa_vld),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .wb_vld(wb_vld),
    .all_vld_set(all_vld_set), .top_we(top_we), .top_nx(top_nx),
    .fault_nx(fault_nx), .ev_push_ok(ev_push_ok), .ev_pop_ok(ev_pop_ok),
    .ev_mm_op(ev_mm_op)
  );

  stkreg_bank #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data), .wa_vld(wa_vld),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .wb_vld(wb_vld),
    .all_vld_set(all_vld_set), .ent_q(ent_q), .vld_q(vld_q)
  );

  stkreg_lanes #(.LOW_W(LOW_W)) lanes_i (
    .word(mm_q), .sz(lane_sz), .sel(lane_sel), .lane(lane_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_r   <= '0;
      fault_r <= 1'b0;
    end else begin
      fault_r <= fault_nx;
      if (top_we) top_r <= top_nx;
    end
  end

  assign top_q     = top_r;
  assign fault_q   = fault_r;
  assign st0_q     = ent_q[phys_top];
  assign st0_valid = vld_q[phys_top];
  assign sti_q     = ent_q[phys_rd];
  assign sti_valid = vld_q[phys_rd];
  assign mm_q      = ent_q[rd_idx][LOW_W-1:0];
endmodule

// File: rtl/stkreg_alias_chk.sv
module stkreg_alias_chk #(
  parameter int ENTRIES = stkreg_pkg::DEF_ENTRIES,
  localparam int PTR_W = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PTR_W-1:0]   top_q,
  input logic               fault_q,
  input logic               st0_valid,
  input logic [ENTRIES-1:0] vld,
  input logic               ev_push_ok,
  input logic               ev_pop_ok,
  input logic               ev_mm_op
);
  // R2
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_ok |=> (top_q == $past(top_q) - PTR_W'(1)) && st0_valid);

  // R3
  pop_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_ok |=> (top_q == $past(top_q) + PTR_W'(1)) && !vld[$past(top_q)]);

  // R4
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> $stable(top_q) && $stable(vld));

  // R8
  mm_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mm_op |=> (top_q == '0) && (&vld));

  // R4
  no_fault_on_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push_ok || ev_pop_ok || ev_mm_op) |=> !fault_q);
endmodule

bind stkreg_alias stkreg_alias_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .top_q(top_q), .fault_q(fault_q),
  .st0_valid(st0_valid), .vld(vld_q), .ev_push_ok(ev_push_ok),
  .ev_pop_ok(ev_pop_ok), .ev_mm_op(ev_mm_op)
);

// File: tb/stkreg_alias_tb_top.sv
`timescale 1ns/100ps
module stkreg_alias_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_idx = 3'd0;
  logic [79:0] cmd_data = '0;
  logic [2:0]  rd_idx = 3'd0;
  logic [1:0]  lane_sz = 2'd0;
  logic [2:0]  lane_sel = 3'd0;
  logic [2:0]  top_q;
  logic        fault_q, st0_valid, sti_valid;
  logic [79:0] st0_q, sti_q;
  logic [63:0] mm_q, lane_q;

  int n_chk = 0;
  int n_bad = 0;

  logic [79:0] m_d [8];
  bit          m_v [8];
  int          m_top = 0;
  bit          m_fault = 0;

  always #2 clk = ~clk;

  stkreg_alias dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_data(cmd_data), .rd_idx(rd_idx), .lane_sz(lane_sz),
    .lane_sel(lane_sel), .top_q(top_q), .fault_q(fault_q), .st0_q(st0_q),
    .st0_valid(st0_valid), .sti_q(sti_q), .sti_valid(sti_valid),
    .mm_q(mm_q), .lane_q(lane_q)
  );

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] lane_ref(input logic [63:0] w, input int sz, input int sel);
    int bits = 8 << sz;
    int cnt  = 64 / bits;
    int n    = sel % cnt;
    logic [63:0] r = '0;
    for (int b = 0; b < bits; b++) r[b] = w[n * bits + b];
    return r;
  endfunction

  function automatic string op_tag(input int op, input bit f);
    if (f) return "R4";
    case (op)
      1: return "R2";
      2: return "R3";
      3, 4: return "R6";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic model(input int op, input int idx, input logic [79:0] d);
    int t = m_top;
    int s = (t + idx) % 8;
    int p = (t + 7) % 8;
    logic [79:0] tmp;
    m_fault = 0;
    case (op)
      1: if (m_v[p]) m_fault = 1; else begin m_d[p] = d; m_v[p] = 1; m_top = p; end
      2: if (!m_v[t]) m_fault = 1; else begin m_v[t] = 0; m_top = (t + 1) % 8; end
      3: if (!m_v[t]) m_fault = 1; else begin m_d[s] = m_d[t]; m_v[s] = 1; end
      4: if (!m_v[s]) m_fault = 1; else begin m_d[t] = m_d[s]; m_v[t] = 1; end
      5: if (!m_v[t] || !m_v[s]) m_fault = 1;
         else begin tmp = m_d[t]; m_d[t] = m_d[s]; m_d[s] = tmp; end
      6: begin
        m_d[idx] = {16'hFFFF, d[63:0]};
        for (int k = 0; k < 8; k++) m_v[k] = 1;
        m_top = 0;
      end
      7: begin
        for (int k = 0; k < 8; k++) m_v[k] = 1;
        m_top = 0;
      end
      default: ;
    endcase
  endtask

  task automatic check_reads(input int ri, input int sz, input int sel);
    int s = (m_top + ri) % 8;
    rd_idx = 3'(ri); lane_sz = 2'(sz); lane_sel = 3'(sel);
    #0.1;
    chk("R5", {79'd0, sti_valid}, {79'd0, m_v[s]});
    chk("R5", sti_q, m_d[s]);
    chk("R10", {16'd0, mm_q}, {16'd0, m_d[ri][63:0]});
    chk("R11", {16'd0, lane_q}, {16'd0, lane_ref(m_d[ri][63:0], sz, sel)});
  endtask

  task automatic do_op(input int op, input int idx, input logic [79:0] d);
    string tag;
    cmd_op = 3'(op); cmd_idx = 3'(idx); cmd_data = d;
    @(posedge clk);
    #0.5;
    cmd_op = 3'd0;
    model(op, idx, d);
    tag = op_tag(op, m_fault);
    chk(tag, {77'd0, top_q}, 80'(m_top));
    chk(tag, {79'd0, fault_q}, {79'd0, m_fault});
    chk(tag, {79'd0, st0_valid}, {79'd0, m_v[m_top]});
    chk(tag, st0_q, m_d[m_top]);
    check_reads(int'($urandom % 8), int'($urandom % 4), int'($urandom % 8));
  endtask

  task automatic sweep();
    for (int r = 0; r < 8; r++) check_reads(r, r % 4, 7 - r);
  endtask

  function automatic logic [79:0] rnd80();
    return {16'($urandom), $urandom, $urandom};
  endfunction

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) begin m_d[k] = '0; m_v[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", {77'd0, top_q}, 80'd0);
    chk("R1", {79'd0, fault_q}, 80'd0);
    chk("R1", {79'd0, st0_valid}, 80'd0);
    sweep();
    do_op(0, 3, rnd80());                      // R1 no-op
    // R2: fill all eight entries, pointer wraps
    for (int k = 0; k < 8; k++) do_op(1, 0, rnd80());
    sweep();
    do_op(1, 0, rnd80());                      // R4 push onto full
    do_op(5, 3, '0);                           // R7 swap
    do_op(5, 0, '0);                           // R7 swap with itself
    do_op(3, 6, '0);                           // R6 copy out
    do_op(4, 2, '0);                           // R6 copy in
    for (int k = 0; k < 8; k++) do_op(2, 0, '0);  // R3 empty the stack
    do_op(2, 0, '0);                           // R4 pop from empty
    do_op(5, 1, '0);                           // R4 swap with empty
    do_op(3, 1, '0);                           // R4 copy from empty top
    do_op(1, 0, rnd80());
    do_op(4, 4, '0);                           // R4 copy from empty slot
    do_op(1, 0, rnd80());
    do_op(6, 5, 80'h1234_0123456789ABCDEF);    // R8 packed write, upper forced
    sweep();
    do_op(7, 0, '0);                           // R9 packed enter
    do_op(2, 0, '0);
    do_op(2, 0, '0);
    do_op(7, 0, '0);                           // R9 after pops
    sweep();
    for (int n = 0; n < 4000; n++) begin
      int w = int'($urandom % 100);
      int op;
      if (w < 30) op = 1;
      else if (w < 55) op = 2;
      else if (w < 65) op = 3;
      else if (w < 75) op = 4;
      else if (w < 88) op = 5;
      else if (w < 93) op = 6;
      else if (w < 96) op = 7;
      else op = 0;
      do_op(op, int'($urandom % 8), rnd80());
      if (n % 64 == 0) sweep();
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule